// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Responder

This block answers on a two-wire serial bus as a small byte-addressed serial EEPROM. The storage behind it is an on-chip array of registers. SCL and SDA are oversampled by the system clock. The block detects START and STOP. It accepts control bytes that carry its device code, then takes a word address of one or two bytes. It writes data into the array or returns data from it, and the pointer advances on every byte. Its only output is an enable for the open-drain pull-down on SDA.

Write data is held in a page buffer and committed to the array when the STOP arrives. The array is then unavailable for a fixed number of clock cycles. During that time every control byte is refused. A random read is done in two steps. The master first sets the pointer with a write that carries no data byte, then sends a repeated START and a read control byte. The parameter `ADDR_W` chooses between two decoding schemes. Up to 11 address bits are decoded with one address byte, and the select bits of the control byte supply the upper address bits. Above 11 bits, two address bytes are used and the select bits must equal the strap input.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After a synchronous reset `sda_pd` is 0 and the slave waits for a START.
- R2: A control byte is laid out as bits 7:4 device code, bits 3:1 select, bit 0 direction (0 = write, 1 = read). The slave acknowledges it only when the device code is 4'b1010. Otherwise it NACKs that byte and every further byte until the next START or STOP.
- R3: With `ADDR_W` <= 11 the select bits are not compared with `sel_i`. Control bits 3:1 become address bits 10:8, cut to `ADDR_W`; with `ADDR_W` = 9 only control bit 1 is used, as address bit 8.
- R4: With `ADDR_W` > 11, two address bytes follow a write control byte, high byte first. The control byte is acknowledged only when its bits 3:1 equal `sel_i`.
- R5: The slave drives `sda_pd` high during the ninth clock of each accepted control byte, each address byte and each write-data byte.
- R6: Write-data bytes reach the array only on STOP. After the busy time, a read returns them.
- R7: Write data goes to consecutive addresses within a page of 2^`PAGE_W` bytes. The low `PAGE_W` pointer bits wrap to 0 at the page end.
- R8: A read control byte after a repeated START returns the byte at the current pointer, MSB first. Each master ACK increments the whole pointer and starts the next byte.
- R9: After a master NACK the slave keeps `sda_pd` low until the next START or STOP.
- R10: After a STOP that ends a write holding at least one data byte, every control byte is NACKed for `BUSY_CYCLES` clocks. After that the slave responds again.
- R11: A START or STOP in the middle of a byte clears the bit count. A START begins a fresh control byte. A STOP commits only the data bytes that were complete.
- R12: `sda_pd` changes only while SCL is low, except when a START or STOP is detected. SDA is sampled on the SCL rising edge.
- R13: A write that carries an address but no data byte starts no busy period, so the next control byte is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sel_i | input | 3 | Strapped select value compared with control bits 3:1 in the two-byte-address mode |
| sda_pd | output | 1 | Pull-down enable for the open-drain SDA driver |

## Verification
Two functions can fall in the same cycle. A STOP that arrives partway through a data byte aborts the bit shifter, and in that same cycle it launches the commit of the buffered bytes and the busy timer. The bench provokes this by breaking off a write three bits into its second data byte. It passes only if a later read returns the completed byte at its address while the next address keeps its old value. A second overlap is between the control-byte match and the busy flag. Right after a committed write the bench sends a valid control byte and expects a NACK, and it expects an ACK to the same byte once the busy time has passed.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDR_HI,
    S_ADDR_LO,
    S_WDATA,
    S_READ,
    S_IGNORE
  } state_t;
endpackage

// File: rtl/eep_bus_mon.sv
module eep_bus_mon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end
  end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edge while the clock is steadily high
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int BUSY_CYCLES = 2000,
  parameter int PAGE_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigger,
  output logic              busy,
  output logic              commit_act,
  output logic [PAGE_W-1:0] commit_idx
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [PAGE_W-1:0] LAST_IDX = {PAGE_W{1'b1}};

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q     <= '0;
      commit_act <= 1'b0;
      commit_idx <= '0;
    end else begin
      if (trigger)
        left_q <= CW'(BUSY_CYCLES);
      else if (left_q != '0)
        left_q <= left_q - CW'(1);

      if (trigger) begin
        commit_act <= 1'b1;
        commit_idx <= '0;
      end else if (commit_act) begin
        if (commit_idx == LAST_IDX) commit_act <= 1'b0;
        commit_idx <= commit_idx + PAGE_W'(1);
      end
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  output logic       sda_pd
);
  localparam bit TWO_BYTE = (ADDR_W > 11);
  localparam int PAGE_N   = 1 << PAGE_W;
  localparam int PB_W     = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, commit_act, commit_req, mem_we, ctl_hit, tx_slot;
  logic [PAGE_W-1:0] commit_idx;
  logic [3:0]        cnt;
  logic [7:0]        shreg, txb, hi_byte, rd_q;
  logic [2:0]        sel_hi;
  logic [15:0]       addr16;
  logic [ADDR_W-1:0] ptr;
  logic [PB_W-1:0]   page_q;
  logic [7:0]        wbuf [PAGE_N];
  logic [PAGE_N-1:0] wvalid;
  state_t            st;

  eep_bus_mon u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) u_busy (
    .clk(clk), .rst(rst), .trigger(commit_req),
    .busy(busy), .commit_act(commit_act), .commit_idx(commit_idx)
  );

  eep_store #(.AW(ADDR_W), .DW(8)) u_store (
    .clk(clk), .we(mem_we), .waddr({page_q, commit_idx}),
    .wdata(wbuf[commit_idx]), .raddr(ptr), .rdata(rd_q)
  );

  assign commit_req = stop_evt & (|wvalid) & ~busy;
  assign mem_we     = commit_act & wvalid[commit_idx];
  assign ctl_hit    = (shreg[7:4] == DEV_CODE) && !busy &&
                      (!TWO_BYTE || shreg[3:1] == sel_i);

  always_comb begin
    if (TWO_BYTE) addr16 = {hi_byte, shreg};
    else          addr16 = {5'b0, sel_hi, shreg};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sda_pd  <= 1'b0;
      tx_slot <= 1'b0;
      shreg   <= '0;
      txb     <= '0;
      hi_byte <= '0;
      sel_hi  <= '0;
      ptr     <= '0;
      page_q  <= '0;
      wvalid  <= '0;
    end else begin
      if (mem_we) wvalid[commit_idx] <= 1'b0;

      if (stop_evt) begin
        st     <= S_IDLE;
        cnt    <= '0;
        sda_pd <= 1'b0;
      end else if (start_evt) begin
        st     <= S_CTRL;
        cnt    <= '0;
        sda_pd <= 1'b0;
      end else if (scl_rise) begin
        if (cnt == 4'd8) begin
          cnt <= '0;
          if (tx_slot && st == S_READ) begin
            if (sda_s) st <= S_IGNORE;
            else       ptr <= ptr + ADDR_W'(1);
          end
        end else begin
          shreg <= {shreg[6:0], sda_s};
          cnt   <= cnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          sda_pd  <= 1'b0;
          tx_slot <= (st == S_READ);
          case (st)
            S_CTRL: begin
              if (ctl_hit) begin
                sda_pd <= 1'b1;
                sel_hi <= shreg[3:1];
                if (shreg[0])      st <= S_READ;
                else if (TWO_BYTE) st <= S_ADDR_HI;
                else               st <= S_ADDR_LO;
              end else begin
                st <= S_IGNORE;
              end
            end
            S_ADDR_HI: begin
              sda_pd  <= 1'b1;
              hi_byte <= shreg;
              st      <= S_ADDR_LO;
            end
            S_ADDR_LO: begin
              sda_pd <= 1'b1;
              ptr    <= addr16[ADDR_W-1:0];
              page_q <= addr16[ADDR_W-1:PAGE_W];
              wvalid <= '0;
              st     <= S_WDATA;
            end
            S_WDATA: begin
              sda_pd                  <= 1'b1;
              wbuf[ptr[PAGE_W-1:0]]   <= shreg;
              wvalid[ptr[PAGE_W-1:0]] <= 1'b1;
              ptr[PAGE_W-1:0]         <= ptr[PAGE_W-1:0] + PAGE_W'(1);
            end
            default: ;
          endcase
        end else if (st == S_READ) begin
          if (cnt == 4'd0) begin
            txb    <= rd_q;
            sda_pd <= ~rd_q[7];
          end else begin
            txb    <= {txb[6:0], 1'b0};
            sda_pd <= ~txb[6];
          end
        end else begin
          sda_pd <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
  import eep_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   scl_s,
  input logic   start_evt,
  input logic   stop_evt,
  input logic   sda_pd,
  input logic   busy,
  input logic   mem_we,
  input state_t st
);
  // R12
  pd_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_pd) && !$past(start_evt) && !$past(stop_evt)) |-> !$past(scl_s));

  // R10
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pd);

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt));

  // R6
  commit_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R9
  quiet_state_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IGNORE || st == S_IDLE) |-> !sda_pd);
endmodule

bind i2c_eeprom_slave eep_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_pd(sda_pd), .busy(busy), .mem_we(mem_we), .st(st)
);

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
  localparam int Q    = 5;
  localparam int BUSY = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, tgt = 1'b0;
  logic pd_a, pd_b, scl_a, sda_a, scl_b, sda_b, line;
  int   checks = 0, errors = 0;
  bit   glitch = 1'b0;

  assign scl_a = tgt ? 1'b1 : scl_m;
  assign sda_a = (tgt ? 1'b1 : sda_m) & ~pd_a;
  assign scl_b = tgt ? scl_m : 1'b1;
  assign sda_b = (tgt ? sda_m : 1'b1) & ~pd_b;
  assign line  = tgt ? sda_b : sda_a;

  i2c_eeprom_slave #(.ADDR_W(9), .PAGE_W(3), .BUSY_CYCLES(BUSY)) i_i2c_eeprom_slave (
    .clk(clk), .rst(rst), .scl_i(scl_a), .sda_i(sda_a), .sel_i(3'b000), .sda_pd(pd_a));

  i2c_eeprom_slave #(.ADDR_W(12), .PAGE_W(3), .BUSY_CYCLES(BUSY)) i_i2c_eeprom_slave_wide (
    .clk(clk), .rst(rst), .scl_i(scl_b), .sda_i(sda_b), .sel_i(3'b101), .sda_pd(pd_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1); sda_m = 1'b0; qw(1); scl_m = 1'b0; qw(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(1); scl_m = 1'b1; qw(1); sda_m = 1'b1; qw(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(1); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1);
    acked = (line == 1'b0);
    qw(1); scl_m = 1'b0; qw(1);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s0;
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      qw(1); scl_m = 1'b1; qw(1);
      s0 = line;
      qw(1);
      if (line !== s0) glitch = 1'b1;
      d = {d[6:0], s0};
      scl_m = 1'b0;
    end
    qw(1);
    sda_m = ~mack; qw(1); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(1); sda_m = 1'b1;
  endtask

  // write with nadr address bytes and n data bytes, acks checked (R5)
  task automatic wr(input logic [7:0] ctl, input int nadr, input logic [15:0] a,
                    input int n, input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic ak;
    logic [7:0] dv [3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    bus_start();
    send_byte(ctl, ak);   chk("R5 control ack", ak, 1);
    if (nadr == 2) begin
      send_byte(a[15:8], ak); chk("R5 high address ack", ak, 1);
    end
    send_byte(a[7:0], ak); chk("R5 address ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(dv[i], ak); chk("R5 data ack", ak, 1);
    end
    bus_stop();
  endtask

  // set pointer, repeated START, read n bytes (last one NACKed)
  task automatic rd(input logic [7:0] ctl, input int nadr, input logic [15:0] a, input int n,
                    output logic [7:0] r0, output logic [7:0] r1);
    logic ak;
    r0 = '0; r1 = '0;
    bus_start();
    send_byte(ctl, ak); chk("R8 setup control ack", ak, 1);
    if (nadr == 2) send_byte(a[15:8], ak);
    send_byte(a[7:0], ak); chk("R8 setup address ack", ak, 1);
    bus_start();
    send_byte(ctl | 8'h01, ak); chk("R8 read control ack", ak, 1);
    recv_byte(n > 1, r0);
    if (n > 1) recv_byte(1'b0, r1);
    qw(2);
    chk("R9 released after NACK", tgt ? pd_b : pd_a, 0);
    bus_stop();
  endtask

  task automatic settle();
    repeat (BUSY + 100) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset pd small", pd_a, 0);
    chk("R1 reset pd wide", pd_b, 0);
  endtask

  task automatic t_small_addr();
    logic [7:0] r0, r1;
    wr(8'hA0, 1, 16'h00F3, 1, 8'h11, 8'h00, 8'h00); settle();
    wr(8'hAE, 1, 16'h00F3, 2, 8'h5A, 8'h3C, 8'h00); settle();
    rd(8'hA0, 1, 16'h00F3, 1, r0, r1);
    chk("R3 low half byte at 0x0F3", r0, 8'h11);
    rd(8'hA2, 1, 16'h00F3, 2, r0, r1);
    chk("R6 committed byte at 0x1F3", r0, 8'h5A);
    chk("R8 incremented read 0x1F4", r1, 8'h3C);
  endtask

  task automatic t_bad_code();
    logic ak;
    bus_start();
    send_byte(8'hB0, ak); chk("R2 wrong code NACK", ak, 0);
    send_byte(8'h00, ak); chk("R2 following byte NACK", ak, 0);
    chk("R2 line released", pd_a, 0);
    bus_stop();
  endtask

  task automatic t_page_wrap();
    logic [7:0] r0, r1;
    wr(8'hA0, 1, 16'h0006, 3, 8'hA1, 8'hA2, 8'hA3); settle();
    rd(8'hA0, 1, 16'h0006, 2, r0, r1);
    chk("R7 byte at 0x006", r0, 8'hA1);
    chk("R7 byte at 0x007", r1, 8'hA2);
    rd(8'hA0, 1, 16'h0000, 1, r0, r1);
    chk("R7 wrapped byte at 0x000", r0, 8'hA3);
  endtask

  task automatic t_busy();
    logic ak;
    logic [7:0] r0, r1;
    wr(8'hA0, 1, 16'h0040, 1, 8'h42, 8'h00, 8'h00);
    bus_start();
    send_byte(8'hA0, ak); chk("R10 NACK while busy", ak, 0);
    bus_stop();
    settle();
    rd(8'hA0, 1, 16'h0040, 1, r0, r1);
    chk("R10 data after busy", r0, 8'h42);
    wr(8'hA0, 1, 16'h0050, 0, 8'h00, 8'h00, 8'h00);
    bus_start();
    send_byte(8'hA0, ak); chk("R13 no busy after address-only write", ak, 1);
    bus_stop();
  endtask

  task automatic t_abort();
    logic ak;
    logic [7:0] r0, r1;
    wr(8'hA0, 1, 16'h0021, 1, 8'h99, 8'h00, 8'h00); settle();
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    rd(8'hA0, 1, 16'h0021, 1, r0, r1);
    chk("R11 read after mid-byte START", r0, 8'h99);
    bus_start();
    send_byte(8'hA0, ak);
    send_byte(8'h20, ak);
    send_byte(8'h77, ak);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    settle();
    rd(8'hA0, 1, 16'h0020, 2, r0, r1);
    chk("R11 complete byte committed", r0, 8'h77);
    chk("R11 partial byte dropped", r1, 8'h99);
  endtask

  task automatic t_wide();
    logic ak;
    logic [7:0] r0, r1;
    tgt = 1'b1;
    qw(2);
    wr(8'hAA, 2, 16'h0ABC, 1, 8'hE7, 8'h00, 8'h00); settle();
    rd(8'hAA, 2, 16'h0ABC, 1, r0, r1);
    chk("R4 two-byte address read", r0, 8'hE7);
    bus_start();
    send_byte(8'hA2, ak); chk("R4 select mismatch NACK", ak, 0);
    bus_stop();
    tgt = 1'b0;
    qw(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_small_addr();
    t_bad_code();
    t_page_wrap();
    t_busy();
    t_abort();
    t_wide();
    chk("R12 read data stable while SCL high", glitch, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule